// File: doc/BRIEF.md
# Host-Read Transmit Queue with Fetch Modes

This block is the read data path of a host bus slave, running from the processor to the host. The processor core pushes words into a small circular transmit queue. The host side pops them while a host read transaction is in progress.

The block keeps a registered transmit-request flag. That flag is gated with two enables to form an interrupt request and a DMA request. Two configuration inputs change the queue's behaviour:

- **Bus mode** selects either a PCI-like mode or a universal bus mode.
- **Fetch-type bit** selects pre-fetch (0) or fetch (1).

In pre-fetch, the flag means "the queue has room", whatever the host is doing. In fetch, the flag can only be set during a host read. When no read is in progress, the path is held empty.

In universal bus fetch mode the queue shrinks to one unbuffered word. In PCI-like mode a format input selects the 32-bit format (0, three words) or the normal format (1, six words). Configuration changes are taken only while the path is idle, meaning empty with no host read active. Taking a change flushes the queue.

Top module: `host_rd_txq`

## Requirements
- R1: After the asynchronous reset, or a one-cycle `sw_rst_i` pulse, the queue is empty and both sticky bits are 0. The request flag is set, so with the reset configuration (PCI-like, pre-fetch, format 1) `req_o` reads 1.
- R2: Queue capacity depends on configuration:
  - universal bus (bus mode 1) with fetch 1: 1 word;
  - PCI-like (bus mode 0) with format 0: 3 words;
  - every other combination: 6 words.
- R3: In pre-fetch (fetch 0), `req_o` is 1 exactly when the fill level is below capacity. It updates one cycle after the write or pop that changes the fill level, and it does not depend on `host_rd_active_i`.
- R4: In fetch mode, `req_o` is 1 only when `host_rd_active_i` was 1 in the previous cycle and the queue is not full.
- R5: In fetch mode, any cycle with `host_rd_active_i` = 0 flushes the queue and drops core writes. `req_o` then reads 0 from the next cycle.
- R6: In universal bus fetch mode, `req_o` rises one cycle after a host read starts. One core write clears it.
- R7: `irq_o` is `req_o` AND `irq_en_i`, and `dma_req_o` is `req_o` AND `dma_en_i`.
- R8: While `hold_rst_i` is 1, `req_o`, `irq_o` and `dma_req_o` are 0 and the queue is flushed. After release, `req_o` reads the set state.
- R9: A core write while the queue is full is dropped and sets the sticky `ovf_o`. Only a reset clears `ovf_o`.
- R10: A host pop from an empty queue leaves it empty and sets the sticky `udf_o`. During that pop, `host_rdata_o` shows the last word popped.
- R11: Changes on `bus_mode_i`, `fetch_i` or `fmt_i` are ignored while the queue holds data or a host read is active. They are taken, with a flush, once the path is idle.
- R12: Words are popped in the order they were written. `host_rdata_o` shows the head word whenever the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_rst_i | input | 1 | Synchronous software reset pulse |
| hold_rst_i | input | 1 | Core-side reset hold level |
| bus_mode_i | input | 1 | 0 PCI-like, 1 universal bus |
| fetch_i | input | 1 | 0 pre-fetch, 1 fetch |
| fmt_i | input | 1 | PCI-like format: 0 selects 3-deep 32-bit format |
| core_wr_i | input | 1 | Core write strobe |
| core_wdata_i | input | W | Core write data |
| host_rd_active_i | input | 1 | Host read transaction in progress |
| host_pop_i | input | 1 | Host pop strobe |
| host_rdata_o | output | W | Head word, or last popped word when empty |
| irq_en_i | input | 1 | Transmit interrupt enable |
| dma_en_i | input | 1 | DMA channel enable for this source |
| req_o | output | 1 | Transmit data request flag |
| irq_o | output | 1 | Transmit interrupt request |
| dma_req_o | output | 1 | Transmit DMA request |
| ovf_o | output | 1 | Sticky overflow |
| udf_o | output | 1 | Sticky underrun |

## Verification
On every cycle, the assertions check the following:

- the fill level stays within the capacity of the active configuration, and within one word in universal bus fetch mode;
- the request flag matches the fill level and the previous cycle's read activity;
- a fetch-mode cycle with no host read empties the path;
- the hold state silences all requests;
- the sticky bits persist.

Some behaviour only the bench scenarios can show:

- the capacity for each of the eight configurations;
- word ordering and the value returned on underrun;
- that a configuration change is deferred until the path is idle;
- that a flush really discarded stored words, seen as a restored request flag.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  typedef enum logic {BUS_PCI = 1'b0, BUS_UNIV = 1'b1} bus_e;

  typedef struct packed {
    bus_e bus;
    logic fetch;
    logic fmt;
  } cfg_t;

  localparam cfg_t CFG_RST = '{bus: BUS_PCI, fetch: 1'b0, fmt: 1'b1};
endpackage

// File: rtl/hrd_cfg.sv
module hrd_cfg
  import hrd_pkg::*;
#(
  parameter int DEPTH_MAX = 6,
  parameter int CW        = $clog2(DEPTH_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic          idle_i,
  output cfg_t          cfg_o,
  output cfg_t          cfg_nxt_o,
  output logic          chg_o,
  output logic [CW-1:0] depth_o,
  output logic [CW-1:0] depth_nxt_o
);
  localparam logic [CW-1:0] D_FULL = CW'(DEPTH_MAX);
  localparam logic [CW-1:0] D_HALF = CW'(DEPTH_MAX / 2);
  localparam logic [CW-1:0] D_ONE  = CW'(1);

  cfg_t cfg_q;

  function automatic logic [CW-1:0] depth_of(cfg_t c);
    if (c.bus == BUS_UNIV && c.fetch) return D_ONE;
    if (c.bus == BUS_PCI && !c.fmt)   return D_HALF;
    return D_FULL;
  endfunction

  assign chg_o       = idle_i && (cfg_i != cfg_q);
  assign cfg_nxt_o   = chg_o ? cfg_i : cfg_q;
  assign cfg_o       = cfg_q;
  assign depth_o     = depth_of(cfg_q);
  assign depth_nxt_o = depth_of(cfg_nxt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= CFG_RST;
    else if (chg_o) cfg_q <= cfg_i;
  end
endmodule

// File: rtl/hrd_ring.sv
module hrd_ring #(
  parameter int W         = 32,
  parameter int DEPTH_MAX = 6,
  parameter int CW        = $clog2(DEPTH_MAX + 1),
  parameter int AW        = (DEPTH_MAX > 1) ? $clog2(DEPTH_MAX) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [CW-1:0] depth_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] fill_o,
  output logic [CW-1:0] fill_nxt_o,
  output logic          ovf_ev_o,
  output logic          udf_ev_o
);
  logic [W-1:0]  mem [DEPTH_MAX];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill_q;
  logic [W-1:0]  last_q;
  logic          full, empty, wr_ok, pop_ok;
  logic [AW-1:0] ptr_top;

  assign full    = fill_q >= depth_i;
  assign empty   = fill_q == '0;
  assign wr_ok   = wr_i && !flush_i && !full;
  assign pop_ok  = pop_i && !flush_i && !empty;
  assign ovf_ev_o = wr_i && !flush_i && full;
  assign udf_ev_o = pop_i && !flush_i && empty;
  assign ptr_top = AW'(depth_i - CW'(1));

  always_comb begin
    if (flush_i) fill_nxt_o = '0;
    else         fill_nxt_o = fill_q + CW'(wr_ok) - CW'(pop_ok);
  end

  assign fill_o  = fill_q;
  assign rdata_o = empty ? last_q : mem[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      fill_q <= fill_nxt_o;
      if (flush_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (wr_ok)  wr_ptr <= (wr_ptr == ptr_top) ? '0 : wr_ptr + AW'(1);
        if (pop_ok) rd_ptr <= (rd_ptr == ptr_top) ? '0 : rd_ptr + AW'(1);
      end
    end
  end

  // last_q survives flushes (only resets clear it) so an underrun has a defined value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (pop_ok) last_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/hrd_req.sv
module hrd_req #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          fetch_nxt_i,
  input  logic          active_i,
  input  logic [CW-1:0] fill_nxt_i,
  input  logic [CW-1:0] depth_nxt_i,
  output logic          req_o
);
  logic room, req_d;

  assign room = fill_nxt_i < depth_nxt_i;

  always_comb begin
    if (set_i)            req_d = 1'b1;
    else if (fetch_nxt_i) req_d = active_i && room;
    else                  req_d = room;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b1;
    else         req_o <= req_d;
  end
endmodule

// File: rtl/host_rd_txq.sv
module host_rd_txq
  import hrd_pkg::*;
#(
  parameter int W         = 32,
  parameter int DEPTH_MAX = 6,
  localparam int CW       = $clog2(DEPTH_MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_rst_i,
  input  logic         hold_rst_i,
  input  logic         bus_mode_i,
  input  logic         fetch_i,
  input  logic         fmt_i,
  input  logic         core_wr_i,
  input  logic [W-1:0] core_wdata_i,
  input  logic         host_rd_active_i,
  input  logic         host_pop_i,
  output logic [W-1:0] host_rdata_o,
  input  logic         irq_en_i,
  input  logic         dma_en_i,
  output logic         req_o,
  output logic         irq_o,
  output logic         dma_req_o,
  output logic         ovf_o,
  output logic         udf_o
);
  cfg_t          cfg_in, cfg_q, cfg_nxt;
  logic          chg, idle, flush, ovf_ev, udf_ev, req_q;
  logic [CW-1:0] depth, depth_nxt, fill, fill_nxt;

  assign cfg_in = '{bus: bus_e'(bus_mode_i), fetch: fetch_i, fmt: fmt_i};
  assign idle   = (fill == '0) && !host_rd_active_i;
  assign flush  = sw_rst_i || hold_rst_i || chg || (cfg_q.fetch && !host_rd_active_i);

  hrd_cfg #(.DEPTH_MAX(DEPTH_MAX), .CW(CW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_in),
    .idle_i      (idle),
    .cfg_o       (cfg_q),
    .cfg_nxt_o   (cfg_nxt),
    .chg_o       (chg),
    .depth_o     (depth),
    .depth_nxt_o (depth_nxt)
  );

  hrd_ring #(.W(W), .DEPTH_MAX(DEPTH_MAX), .CW(CW)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .depth_i    (depth),
    .wr_i       (core_wr_i),
    .wdata_i    (core_wdata_i),
    .pop_i      (host_pop_i),
    .rdata_o    (host_rdata_o),
    .fill_o     (fill),
    .fill_nxt_o (fill_nxt),
    .ovf_ev_o   (ovf_ev),
    .udf_ev_o   (udf_ev)
  );

  hrd_req #(.CW(CW)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (sw_rst_i || hold_rst_i),
    .fetch_nxt_i (cfg_nxt.fetch),
    .active_i    (host_rd_active_i),
    .fill_nxt_i  (fill_nxt),
    .depth_nxt_i (depth_nxt),
    .req_o       (req_q)
  );

  assign req_o     = req_q && !hold_rst_i;
  assign irq_o     = req_o && irq_en_i;
  assign dma_req_o = req_o && dma_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else if (sw_rst_i) begin
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      if (ovf_ev) ovf_o <= 1'b1;
      if (udf_ev) udf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hrd_txq_chk.sv
module hrd_txq_chk
  import hrd_pkg::*;
#(
  parameter int CW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sw_rst_i,
  input logic          hold_rst_i,
  input logic          host_rd_active_i,
  input logic          irq_en_i,
  input logic          dma_en_i,
  input logic          req_o,
  input logic          irq_o,
  input logic          dma_req_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic [CW-1:0] fill_i,
  input logic [CW-1:0] depth_i,
  input cfg_t          cfg_i
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_fill_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= depth_i);

  assert_prefetch_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(sw_rst_i) && !$past(hold_rst_i) && !hold_rst_i && !cfg_i.fetch)
    |-> (req_o == (fill_i < depth_i)));

  assert_fetch_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !$past(sw_rst_i) && !$past(hold_rst_i) && !hold_rst_i && cfg_i.fetch)
    |-> (req_o == ($past(host_rd_active_i) && (fill_i < depth_i))));

  assert_fetch_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.fetch && !host_rd_active_i) |=> (fill_i == '0));

  assert_ufetch_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.bus == BUS_UNIV && cfg_i.fetch) |-> (fill_i <= CW'(1)));

  assert_gate_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || dma_req_o) |-> (req_o && (irq_o ? irq_en_i : dma_en_i)));

  assert_hold_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |-> (!req_o && !irq_o && !dma_req_o));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !sw_rst_i) |=> ovf_o);

  assert_udf_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (udf_o && !sw_rst_i) |=> udf_o);
endmodule

bind host_rd_txq hrd_txq_chk #(.CW(CW)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .sw_rst_i         (sw_rst_i),
  .hold_rst_i       (hold_rst_i),
  .host_rd_active_i (host_rd_active_i),
  .irq_en_i         (irq_en_i),
  .dma_en_i         (dma_en_i),
  .req_o            (req_o),
  .irq_o            (irq_o),
  .dma_req_o        (dma_req_o),
  .ovf_o            (ovf_o),
  .udf_o            (udf_o),
  .fill_i           (fill),
  .depth_i          (depth),
  .cfg_i            (cfg_q)
);

// File: tb/tb_host_rd_txq.sv
`timescale 1ns/1ps
module tb_host_rd_txq;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sw_rst_i = 1'b0, hold_rst_i = 1'b0;
  logic         bus_mode_i = 1'b0, fetch_i = 1'b0, fmt_i = 1'b1;
  logic         core_wr_i = 1'b0;
  logic [W-1:0] core_wdata_i = '0;
  logic         host_rd_active_i = 1'b0, host_pop_i = 1'b0;
  logic [W-1:0] host_rdata_o;
  logic         irq_en_i = 1'b0, dma_en_i = 1'b0;
  logic         req_o, irq_o, dma_req_o, ovf_o, udf_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  host_rd_txq #(.W(W), .DEPTH_MAX(6)) dut (.*);

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic core_write(input logic [W-1:0] d);
    core_wr_i = 1'b1;
    core_wdata_i = d;
    tick();
    core_wr_i = 1'b0;
  endtask

  task automatic host_pop();
    host_pop_i = 1'b1;
    tick();
    host_pop_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 reset req", W'(req_o), 1);
    chk("R1 reset ovf", W'(ovf_o), 0);
    chk("R1 reset udf", W'(udf_o), 0);

    for (int c = 0; c < 8; c++) begin
      int dep;
      logic bm, ft, fm;
      logic [W-1:0] base;
      bm = c[2];
      ft = c[1];
      fm = c[0];
      dep = (bm && ft) ? 1 : (!bm && !fm) ? 3 : 6;
      base = W'(32'h100 * (c + 1));

      host_rd_active_i = 1'b0;
      bus_mode_i = bm;
      fetch_i = ft;
      fmt_i = fm;
      tick();
      tick();
      chk(ft ? "R5 idle fetch req" : "R3 idle prefetch req", W'(req_o), W'(!ft));

      host_rd_active_i = 1'b1;
      tick();
      chk(bm && ft ? "R6 read start req" : "R4 read start req", W'(req_o), 1);

      for (int i = 0; i < dep; i++) begin
        core_write(base + W'(i));
        chk(bm && ft ? "R6 write req" : "R2 fill req", W'(req_o), W'(i + 1 < dep));
      end
      core_write(32'hdead);
      chk("R9 ovf set", W'(ovf_o), 1);
      chk("R9 req full", W'(req_o), 0);

      for (int i = 0; i < dep; i++) begin
        chk("R12 order", host_rdata_o, base + W'(i));
        host_pop();
        chk("R3 req after pop", W'(req_o), 1);
      end
      host_pop();
      chk("R10 udf set", W'(udf_o), 1);
      chk("R10 last word", host_rdata_o, base + W'(dep - 1));
      chk("R9 ovf sticky", W'(ovf_o), 1);

      sw_rst_i = 1'b1;
      tick();
      sw_rst_i = 1'b0;
      chk("R1 swrst ovf", W'(ovf_o), 0);
      chk("R1 swrst udf", W'(udf_o), 0);
      chk("R1 swrst req", W'(req_o), 1);

      irq_en_i = 1'b1;
      dma_en_i = 1'b1;
      #1;
      chk("R7 irq on", W'(irq_o), 1);
      chk("R7 dma on", W'(dma_req_o), 1);
      dma_en_i = 1'b0;
      #1;
      chk("R7 dma gated", W'(dma_req_o), 0);
      chk("R7 irq kept", W'(irq_o), 1);
      for (int i = 0; i < dep; i++) core_write(base + W'(16 + i));
      chk("R7 irq no req", W'(irq_o), 0);
      chk("R9 no ovf at cap", W'(ovf_o), 0);
      irq_en_i = 1'b0;

      host_rd_active_i = 1'b0;
      tick();
      if (ft) begin
        chk("R5 req drop", W'(req_o), 0);
        host_rd_active_i = 1'b1;
        tick();
        chk("R5 flushed", W'(req_o), 1);
        host_rd_active_i = 1'b0;
      end else begin
        chk("R3 host idle full", W'(req_o), 0);
      end

      hold_rst_i = 1'b1;
      tick();
      chk("R8 hold req", W'(req_o), 0);
      hold_rst_i = 1'b0;
      tick();
      chk("R8 after hold", W'(req_o), W'(!ft));
    end

    // R11: change deferred while data held
    host_rd_active_i = 1'b0;
    bus_mode_i = 1'b0;
    fetch_i = 1'b0;
    fmt_i = 1'b1;
    tick();
    tick();
    host_rd_active_i = 1'b1;
    core_write(32'h11);
    core_write(32'h22);
    fmt_i = 1'b0;
    for (int i = 0; i < 4; i++) core_write(W'(32'h33 + i));
    chk("R11 six taken", W'(req_o), 0);
    chk("R11 no ovf", W'(ovf_o), 0);
    chk("R11 head", host_rdata_o, 32'h11);
    for (int i = 0; i < 6; i++) host_pop();
    host_rd_active_i = 1'b0;
    tick();
    tick();
    for (int i = 0; i < 2; i++) core_write(W'(i));
    chk("R11 two of three", W'(req_o), 1);
    core_write(32'h5);
    chk("R11 three deep", W'(req_o), 0);
    hold_rst_i = 1'b1;
    tick();
    hold_rst_i = 1'b0;
    tick();
    chk("R8 flush", W'(req_o), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule